// File: doc/BRIEF.md
# Paired-Lane Integer Matrix Multiply Engine

This block multiplies two square signed-integer matrices, C = A x B, on a fixed schedule of 32 compute cycles at the default size of 16x16. Software or a neighbouring block first fills two operand stores through a single load port. Each load writes one packed word that carries two neighbouring elements along the inner dimension: two elements of one row of A, or two elements of one column of B. A one-cycle start pulse then launches the computation. Once it finishes, a done flag rises and every element of C can be read at any time by row and column address.

The datapath has two groups of lanes, with one lane per row in each group. In every cycle a lane takes one packed pair of A and multiplies it against two packed pairs of B, which belong to two horizontally neighbouring output columns. It accumulates two two-term dot products at once. The output is swept as wrapped diagonals: the cells (i, (i+d) mod N) form diagonal d. Each phase of N/2 cycles finishes four neighbouring diagonals, and N/4 phases in sequence cover the whole matrix. Every lane clears its accumulators at the start of each phase and writes its two cells into the result buffer on the last cycle of the phase.

Top module: `dot2_matmul_core`

## Requirements
- R1: A load with `ld_sel_i`=0 writes row `ld_idx_i` of A. A load with `ld_sel_i`=1 writes column `ld_idx_i` of B. Bits [7:0] of `ld_data_i` hold the element at inner index 2*`ld_pair_i`, and bits [15:8] hold the element at inner index 2*`ld_pair_i`+1.
- R2: After a run, `rd_data_o` holds the exact signed sum over k of A[i][k]*B[k][j] for `rd_row_i`=i and `rd_col_i`=j, in 24-bit two's complement.
- R3: No input values overflow the result. With all elements at -128 every cell reads 262144. With all elements at 127 every cell reads 258064. With A at -128 and B at 127 every cell reads -260096.
- R4: If `start_i` is sampled high at clock edge e0 while the block is idle or done, `done_o` is low after edges e0 through e31 and first reads high after edge e32.
- R5: `done_o` stays high until the next accepted start, and it is low after the edge that samples that start.
- R6: A start pulse that arrives during a run is ignored, and the running computation still completes after edge e32.
- R7: Loads presented during a run are ignored. The operands stored before the start determine the result.
- R8: The read port is combinational, and the results stay readable, unchanged, for as long as `done_o` stays high.
- R9: After reset, `done_o` is low and every element of C reads 0.
- R10: Back-to-back runs are independent, because accumulators restart at each phase and nothing from a previous run leaks into the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | Operand load strobe |
| ld_sel_i | input | 1 | 0 selects A rows, 1 selects B columns |
| ld_idx_i | input | 4 | Row of A or column of B |
| ld_pair_i | input | 3 | Pair index along the inner dimension |
| ld_data_i | input | 16 | Two packed signed 8-bit elements |
| start_i | input | 1 | One-cycle start pulse |
| done_o | output | 1 | Result valid flag |
| rd_row_i | input | 4 | Result row address |
| rd_col_i | input | 4 | Result column address |
| rd_data_o | output | 24 | Signed result element |

## Verification
The bench builds the block with its defaults: 16x16 matrices, 8-bit elements and 24-bit accumulators. At that size a run takes exactly 32 cycles, uses all four phases, and includes diagonals that wrap past column 15, so the latency edge and the wrapped column indexing can be checked exactly. The 24-bit accumulator against 8-bit extremes lets the all-minimum, all-maximum and mixed-sign matrices probe the sign-extension path of every product with values close to the 2^18 magnitude bound.

// File: rtl/dpmm_pkg.sv
package dpmm_pkg;

    // Sequencer states shared by the engine and its checker
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/dpmm_sequencer.sv
module dpmm_sequencer
    import dpmm_pkg::*;
#(
    parameter int unsigned N = 16
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         start_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [$clog2(N/4)-1:0]       phase_o,
    output logic [$clog2(N/2)-1:0]       step_o,
    output logic                         first_o,
    output logic                         last_o
);
    localparam int unsigned STEPS  = N / 2;
    localparam int unsigned PHASES = N / 4;
    localparam int unsigned SW     = $clog2(STEPS);
    localparam int unsigned PW     = $clog2(PHASES);

    typedef struct packed {
        seq_state_e    state;
        logic [PW-1:0] phase;
        logic [SW-1:0] step;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.state)
            SEQ_RUN: begin
                if (s_q.step == SW'(STEPS - 1)) begin
                    s_d.step = '0;
                    if (s_q.phase == PW'(PHASES - 1)) begin
                        s_d.phase = '0;
                        s_d.state = SEQ_DONE;
                    end else begin
                        s_d.phase = s_q.phase + 1'b1;
                    end
                end else begin
                    s_d.step = s_q.step + 1'b1;
                end
            end
            default: begin
                if (start_i) begin
                    s_d.state = SEQ_RUN;
                    s_d.phase = '0;
                    s_d.step  = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{state: SEQ_IDLE, phase: '0, step: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o  = (s_q.state == SEQ_RUN);
    assign done_o  = (s_q.state == SEQ_DONE);
    assign phase_o = s_q.phase;
    assign step_o  = s_q.step;
    assign first_o = (s_q.step == '0);
    assign last_o  = (s_q.step == SW'(STEPS - 1));

endmodule

// File: rtl/dpmm_operand_store.sv
module dpmm_operand_store #(
    parameter int unsigned N      = 16,
    parameter int unsigned ELEM_W = 8
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                ld_valid_i,
    input  logic                                ld_sel_i,
    input  logic [$clog2(N)-1:0]                ld_idx_i,
    input  logic [$clog2(N/2)-1:0]              ld_pair_i,
    input  logic [2*ELEM_W-1:0]                 ld_data_i,
    input  logic                                lock_i,
    input  logic [$clog2(N/2)-1:0]              step_i,
    output logic [N-1:0][2*ELEM_W-1:0]          a_rows_o,
    output logic [N-1:0][2*ELEM_W-1:0]          b_cols_o
);
    localparam int unsigned PAIRS  = N / 2;
    localparam int unsigned PAIR_W = 2 * ELEM_W;

    typedef logic [N-1:0][PAIRS-1:0][PAIR_W-1:0] bank_t;

    typedef struct packed {
        bank_t a;
        bank_t b;
    } store_t;

    store_t st_d, st_q;

    // Operand words are frozen while a run is in progress
    always_comb begin
        st_d = st_q;
        if (ld_valid_i && !lock_i) begin
            if (ld_sel_i) begin
                st_d.b[ld_idx_i][ld_pair_i] = ld_data_i;
            end else begin
                st_d.a[ld_idx_i][ld_pair_i] = ld_data_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Every row / column presents the pair for the current step
    for (genvar k = 0; k < N; k++) begin : g_port
        assign a_rows_o[k] = st_q.a[k][step_i];
        assign b_cols_o[k] = st_q.b[k][step_i];
    end

endmodule

// File: rtl/dpmm_lane.sv
module dpmm_lane #(
    parameter int unsigned ELEM_W = 8,
    parameter int unsigned ACC_W  = 24
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  en_i,
    input  logic                  clr_i,
    input  logic [2*ELEM_W-1:0]   a_pair_i,
    input  logic [2*ELEM_W-1:0]   b0_pair_i,
    input  logic [2*ELEM_W-1:0]   b1_pair_i,
    output logic [ACC_W-1:0]      sum0_o,
    output logic [ACC_W-1:0]      sum1_o
);
    localparam int unsigned PROD_W = 2 * ELEM_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc0;
        logic [ACC_W-1:0] acc1;
    } lane_t;

    lane_t l_d, l_q;

    // Two-term signed dot product of packed pairs
    function automatic logic [ACC_W-1:0] dot2(input logic [PROD_W-1:0] a,
                                              input logic [PROD_W-1:0] b);
        logic signed [ELEM_W-1:0] a0, a1, b0, b1;
        logic signed [PROD_W-1:0] p0, p1;
        a0 = a[ELEM_W-1:0];
        a1 = a[PROD_W-1:ELEM_W];
        b0 = b[ELEM_W-1:0];
        b1 = b[PROD_W-1:ELEM_W];
        p0 = PROD_W'(a0) * PROD_W'(b0);
        p1 = PROD_W'(a1) * PROD_W'(b1);
        return ACC_W'(p0) + ACC_W'(p1);
    endfunction

    logic [ACC_W-1:0] base0, base1, nx0, nx1;

    always_comb begin
        base0 = clr_i ? '0 : l_q.acc0;
        base1 = clr_i ? '0 : l_q.acc1;
        nx0   = base0 + dot2(a_pair_i, b0_pair_i);
        nx1   = base1 + dot2(a_pair_i, b1_pair_i);
        l_d   = l_q;
        if (en_i) begin
            l_d.acc0 = nx0;
            l_d.acc1 = nx1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    // Value including the current cycle, used by the last-step writeback
    assign sum0_o = nx0;
    assign sum1_o = nx1;

endmodule

// File: rtl/dpmm_result_buf.sv
module dpmm_result_buf #(
    parameter int unsigned N     = 16,
    parameter int unsigned ACC_W = 24
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic                                 wr_en_i,
    input  logic [$clog2(N/4)-1:0]               phase_i,
    input  logic [1:0][N-1:0][1:0][ACC_W-1:0]    res_i,
    input  logic [$clog2(N)-1:0]                 rd_row_i,
    input  logic [$clog2(N)-1:0]                 rd_col_i,
    output logic [ACC_W-1:0]                     rd_data_o
);
    localparam int unsigned PW = $clog2(N / 4);

    logic [N-1:0][N-1:0][ACC_W-1:0] c_d, c_q;

    // Cell (i,j) sits on diagonal (j-i) mod N; the phase owning that
    // diagonal, the lane group and the pair half follow from it.
    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj < N; gj++) begin : g_col
            localparam int unsigned DIAG = (gj + N - gi) % N;
            localparam int unsigned GRP  = (DIAG / 2) % 2;
            localparam int unsigned HALF = DIAG % 2;
            logic hit;
            assign hit = wr_en_i && (phase_i == PW'(DIAG / 4));
            assign c_d[gi][gj] = hit ? res_i[GRP][gi][HALF] : c_q[gi][gj];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_data_o = c_q[rd_row_i][rd_col_i];

endmodule

// File: rtl/dot2_matmul_core.sv
module dot2_matmul_core #(
    parameter int unsigned N      = 16,
    parameter int unsigned ELEM_W = 8,
    parameter int unsigned ACC_W  = 24
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       ld_valid_i,
    input  logic                       ld_sel_i,
    input  logic [$clog2(N)-1:0]       ld_idx_i,
    input  logic [$clog2(N/2)-1:0]     ld_pair_i,
    input  logic [2*ELEM_W-1:0]        ld_data_i,
    input  logic                       start_i,
    output logic                       done_o,
    input  logic [$clog2(N)-1:0]       rd_row_i,
    input  logic [$clog2(N)-1:0]       rd_col_i,
    output logic [ACC_W-1:0]           rd_data_o
);
    // N must be a power of two, at least 8
    localparam int unsigned IW     = $clog2(N);
    localparam int unsigned SW     = $clog2(N / 2);
    localparam int unsigned PW     = $clog2(N / 4);
    localparam int unsigned PAIR_W = 2 * ELEM_W;
    localparam int unsigned GROUPS = 2;

    logic              seq_busy;
    logic [PW-1:0]     seq_phase;
    logic [SW-1:0]     seq_step;
    logic              seq_first;
    logic              seq_last;

    logic [N-1:0][PAIR_W-1:0]                  a_rows;
    logic [N-1:0][PAIR_W-1:0]                  b_cols;
    logic [GROUPS-1:0][N-1:0][1:0][ACC_W-1:0]  lane_res;

    dpmm_sequencer #(.N(N)) u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .busy_o  (seq_busy),
        .done_o  (done_o),
        .phase_o (seq_phase),
        .step_o  (seq_step),
        .first_o (seq_first),
        .last_o  (seq_last)
    );

    dpmm_operand_store #(.N(N), .ELEM_W(ELEM_W)) u_ops (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ld_valid_i (ld_valid_i),
        .ld_sel_i   (ld_sel_i),
        .ld_idx_i   (ld_idx_i),
        .ld_pair_i  (ld_pair_i),
        .ld_data_i  (ld_data_i),
        .lock_i     (seq_busy),
        .step_i     (seq_step),
        .a_rows_o   (a_rows),
        .b_cols_o   (b_cols)
    );

    // Lane k of group g in phase p owns columns k+4p+2g and k+4p+2g+1,
    // both taken modulo N by the IW-bit wrap.
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar k = 0; k < N; k++) begin : g_lane
            logic [IW-1:0] col0, col1;
            assign col0 = IW'(k) + {seq_phase, 2'b00} + IW'(2 * g);
            assign col1 = col0 + 1'b1;

            dpmm_lane #(.ELEM_W(ELEM_W), .ACC_W(ACC_W)) u_lane (
                .clk_i     (clk_i),
                .rst_ni    (rst_ni),
                .en_i      (seq_busy),
                .clr_i     (seq_first),
                .a_pair_i  (a_rows[k]),
                .b0_pair_i (b_cols[col0]),
                .b1_pair_i (b_cols[col1]),
                .sum0_o    (lane_res[g][k][0]),
                .sum1_o    (lane_res[g][k][1])
            );
        end
    end

    dpmm_result_buf #(.N(N), .ACC_W(ACC_W)) u_res (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (seq_busy && seq_last),
        .phase_i   (seq_phase),
        .res_i     (lane_res),
        .rd_row_i  (rd_row_i),
        .rd_col_i  (rd_col_i),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/dpmm_checker.sv
module dpmm_checker #(
    parameter int unsigned N     = 16,
    parameter int unsigned ACC_W = 24
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   start_i,
    input logic                   busy_i,
    input logic                   done_i,
    input logic [$clog2(N)-1:0]   rd_row_i,
    input logic [$clog2(N)-1:0]   rd_col_i,
    input logic [ACC_W-1:0]       rd_data_i
);
    localparam int unsigned TOTAL = (N / 4) * (N / 2);

    // Cycles counted since the last accepted start
    int unsigned since_start;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_start <= 0;
        end else if (start_i && !busy_i) begin
            since_start <= 0;
        end else if (busy_i && since_start < TOTAL + 4) begin
            since_start <= since_start + 1;
        end
    end

    // R4: done rises exactly TOTAL cycles after the accepted start
    p_done_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_i) |-> since_start == TOTAL);

    // R4: a run never lasts longer than TOTAL cycles
    p_run_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |-> since_start < TOTAL);

    // R5: done holds until a start arrives
    p_done_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i && !start_i |=> done_i);

    // R5: a start while done clears the flag
    p_done_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i && start_i |=> !done_i);

    // R6: a start during a run neither stops nor restarts it
    p_start_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i && start_i |=> busy_i || done_i);

    // R5: running and done are never both set
    p_busy_done_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_i && done_i));

    // R8: results stay put while done holds and the address is unchanged
    p_result_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i && $past(done_i) && $stable(rd_row_i) && $stable(rd_col_i)
        |-> $stable(rd_data_i));

endmodule

bind dot2_matmul_core dpmm_checker #(.N(N), .ACC_W(ACC_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .busy_i    (seq_busy),
    .done_i    (done_o),
    .rd_row_i  (rd_row_i),
    .rd_col_i  (rd_col_i),
    .rd_data_i (rd_data_o)
);

// File: tb/dot2_matmul_core_tb_top.sv
module dot2_matmul_core_tb_top;
    localparam int N  = 16;
    localparam int EW = 8;
    localparam int AW = 24;

    logic            clk_i = 1'b0;
    logic            rst_ni = 1'b0;
    logic            ld_valid_i = 1'b0;
    logic            ld_sel_i = 1'b0;
    logic [3:0]      ld_idx_i = '0;
    logic [2:0]      ld_pair_i = '0;
    logic [15:0]     ld_data_i = '0;
    logic            start_i = 1'b0;
    logic            done_o;
    logic [3:0]      rd_row_i = '0;
    logic [3:0]      rd_col_i = '0;
    logic [AW-1:0]   rd_data_o;

    int n_tests = 0;
    int n_fail  = 0;

    int a_m   [N][N];
    int b_m   [N][N];
    int c_ref [N][N];

    always #4 clk_i = ~clk_i;

    dot2_matmul_core #(.N(N), .ELEM_W(EW), .ACC_W(AW)) dut_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ld_valid_i (ld_valid_i),
        .ld_sel_i   (ld_sel_i),
        .ld_idx_i   (ld_idx_i),
        .ld_pair_i  (ld_pair_i),
        .ld_data_i  (ld_data_i),
        .start_i    (start_i),
        .done_o     (done_o),
        .rd_row_i   (rd_row_i),
        .rd_col_i   (rd_col_i),
        .rd_data_o  (rd_data_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill_rand();
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                a_m[i][j] = int'($urandom_range(255)) - 128;
                b_m[i][j] = int'($urandom_range(255)) - 128;
            end
        end
    endtask

    task automatic fill_const(input int av, input int bv);
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                a_m[i][j] = av;
                b_m[i][j] = bv;
            end
        end
    endtask

    task automatic compute_ref();
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                int s = 0;
                for (int k = 0; k < N; k++) s += a_m[i][k] * b_m[k][j];
                c_ref[i][j] = s;
            end
        end
    endtask

    // R1: low byte = even inner index, high byte = odd inner index
    task automatic load_all();
        for (int r = 0; r < N; r++) begin
            for (int p = 0; p < N / 2; p++) begin
                ld_valid_i = 1'b1;
                ld_sel_i   = 1'b0;
                ld_idx_i   = 4'(r);
                ld_pair_i  = 3'(p);
                ld_data_i  = {8'(a_m[r][2*p+1]), 8'(a_m[r][2*p])};
                @(negedge clk_i);
            end
        end
        for (int c = 0; c < N; c++) begin
            for (int p = 0; p < N / 2; p++) begin
                ld_valid_i = 1'b1;
                ld_sel_i   = 1'b1;
                ld_idx_i   = 4'(c);
                ld_pair_i  = 3'(p);
                ld_data_i  = {8'(b_m[2*p+1][c]), 8'(b_m[2*p][c])};
                @(negedge clk_i);
            end
        end
        ld_valid_i = 1'b0;
    endtask

    // Start at edge e0, count edges until done is seen
    task automatic run(input int mid_start, input bit mid_load, output int lat);
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        chk(done_o == 1'b0, "R5 done low after start edge", int'(done_o), 0);
        lat = 0;
        while (!done_o && lat < 100) begin
            start_i = (lat == mid_start);
            if (mid_load) begin
                ld_valid_i = 1'b1;
                ld_sel_i   = lat[0];
                ld_idx_i   = 4'(lat % N);
                ld_pair_i  = 3'(lat % (N / 2));
                ld_data_i  = 16'h7f80;
            end
            @(negedge clk_i);
            lat++;
        end
        start_i    = 1'b0;
        ld_valid_i = 1'b0;
    endtask

    task automatic compare_all(input string req);
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                int act;
                rd_row_i = 4'(i);
                rd_col_i = 4'(j);
                #1;
                act = int'($signed(rd_data_o));
                chk(act == c_ref[i][j], req, act, c_ref[i][j]);
            end
        end
    endtask

    task automatic full_case(input string req, input int mid_start, input bit mid_load);
        int lat;
        load_all();
        compute_ref();
        run(mid_start, mid_load, lat);
        chk(lat == 32, "R4 done latency", lat, 32);
        compare_all(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        n_fail++;
        n_tests++;
        $display("FAIL R4 watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd5521));
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R9: reset state
        chk(done_o == 1'b0, "R9 done low after reset", int'(done_o), 0);
        fill_const(0, 0);
        compute_ref();
        compare_all("R9 buffer zero after reset");

        // R1 R2: random operands
        fill_rand();
        full_case("R2 random product R1 packing", -1, 1'b0);

        // R5 R8: done holds, results stay readable
        for (int w = 0; w < 6; w++) begin
            @(negedge clk_i);
            chk(done_o == 1'b1, "R5 done holds", int'(done_o), 1);
        end
        compare_all("R8 results persist while done");

        // R3: extreme values
        fill_const(-128, -128);
        full_case("R3 all minimum", -1, 1'b0);
        fill_const(127, 127);
        full_case("R3 all maximum", -1, 1'b0);
        fill_const(-128, 127);
        full_case("R3 mixed sign extremes", -1, 1'b0);

        // R6 R7: start and loads during a run are ignored
        fill_rand();
        full_case("R7 loads during run ignored R6", 10, 1'b1);

        // R10: another independent run with fresh operands
        fill_rand();
        for (int i = 0; i < N; i++) b_m[i][(i + 5) % N] = -128;
        full_case("R10 back-to-back run", 31, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule